// File: doc/BRIEF.md
# External Bus Cycle Terminator with Timeout Monitor

This block closes out cycles on a shared external bus. The bus controller starts a cycle with a one-cycle start strobe. The block then watches the acknowledge and error-termination inputs and tells the internal side when the cycle is over and whether it ended cleanly. All ports carry active-high logical values. Conversion to the pad polarity is done outside the block.

An optional monitor counts bus cycles from the start strobe against a programmed limit. If no acknowledge arrives within that limit, the block drives the shared error line itself. It drives that line only for one asserted cycle and one actively negated cycle, and it releases the line in every other cycle.

Error indications from other agents pass through a short register pipeline before the block acts on them. Because of that delay, an error that coincides with the final acknowledge can be lost. There is one exception: an error seen in the same cycle as the start strobe is always honoured.

If an external error ends a cycle while the internal transfer behind it is still busy, the block refuses new start strobes until that internal transfer is finished.

Top module: `bus_term_mon`

## Requirements
- R1: In a running cycle, `ta_i` high with no pending error ends the cycle. `done_o` pulses in that same clock cycle with `err_o` low. Latency is counted in clock cycles after the start-strobe cycle.
- R2: `tea_ext_i` high in cycle k after the start (k at least 1) ends the cycle with `done_o` and `err_o` high in cycle k+1, even if `ta_i` is also high in cycle k+1. A `tea_ext_i` that arrives only in the same cycle as the `ta_i` that ends the cycle has no effect, and the cycle ends normally. The bench builds the block with a one-stage error pipeline.
- R3: `tea_ext_i` high in the cycle where a start strobe is accepted ends that cycle with an error in the first cycle after the start, even if `ta_i` is high in that cycle.
- R4: The monitor is armed when `mon_en_i` is 1 and `mon_limit_i` (L) is non-zero; both are captured at the start strobe. If the monitor is armed and no termination occurs in cycles 1..L, the block ends the cycle with an error in cycle L+1. A `ta_i` in cycle L still gives a normal end.
- R5: On a timeout, `tea_oe_o` and `tea_out_o` are both 1 in the timeout cycle. In the next cycle `tea_oe_o` is 1 and `tea_out_o` is 0. After that `tea_oe_o` is 0. In every other cycle `tea_oe_o` is 0.
- R6: When `mon_en_i` is 0 or `mon_limit_i` is 0, no timeout occurs. The cycle waits for `ta_i` for as long as it takes.
- R7: `to_flag_o` is updated from the cycle after each `done_o` pulse and then holds. It is 1 if that cycle ended by a monitor timeout and 0 otherwise.
- R8: If an external error ends a cycle while `int_busy_i` is 1, `busy_o` stays 1 and start strobes are ignored (no `done_o` follows them) until `int_busy_i` is sampled 0. `busy_o` falls in the cycle after that sample.
- R9: Synchronous reset sets `busy_o`, `done_o`, `tea_oe_o` and `to_flag_o` to 0.
- R10: `done_o` is a single-cycle pulse: it is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Cycle start strobe from the bus controller |
| ta_i | input | 1 | Transfer acknowledge seen on the bus |
| tea_ext_i | input | 1 | Error termination driven by another agent |
| int_busy_i | input | 1 | Internal side of the transfer still in progress |
| mon_en_i | input | 1 | Monitor enable, captured at start |
| mon_limit_i | input | CW | Monitor limit in cycles, captured at start; 0 disables |
| busy_o | output | 1 | A cycle is running or the block is draining |
| done_o | output | 1 | One-cycle pulse when a cycle ends |
| err_o | output | 1 | Valid with done_o: the cycle ended in error |
| to_flag_o | output | 1 | The last cycle ended by a monitor timeout |
| tea_oe_o | output | 1 | Output enable for the shared error line |
| tea_out_o | output | 1 | Value driven on the error line while enabled |

## Verification
The bench builds the block with a 4-bit limit and a single-stage error pipeline. This keeps timeouts within a few cycles and places the boundary between an honoured and a missed external error exactly one cycle before the final acknowledge. With a limit of 3, the bench can test an acknowledge that lands exactly on the last allowed cycle, a timeout one cycle later, and the full assert, negate and release pattern on the error line. Zero-wait acknowledges, an error that coincides with the start, and a drain with ignored starts are covered by the same scoreboard, and the scoreboard fails on any completion it did not expect.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RUN   = 3'd1,
      ST_TOUT  = 3'd2,
      ST_NEG   = 3'd3,
      ST_DRAIN = 3'd4
   } term_state_t;

   typedef enum logic [1:0] {
      OC_NONE    = 2'd0,
      OC_OK      = 2'd1,
      OC_ERR     = 2'd2,
      OC_TIMEOUT = 2'd3
   } term_outcome_t;
endpackage

// File: rtl/tea_sampler.sv
module tea_sampler #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic tea_raw,
   output logic tea_late
);
   initial begin
      if (STAGES < 1 || STAGES > 2) $error("tea_sampler: STAGES must be 1 or 2");
   end

   generate
      if (STAGES == 1) begin : g_one
         logic q1;
         always_ff @(posedge clk) begin
            if (rst) q1 <= 1'b0;
            else     q1 <= tea_raw;
         end
         assign tea_late = q1;
      end else begin : g_two
         logic [1:0] qs;
         always_ff @(posedge clk) begin
            if (rst) qs <= '0;
            else     qs <= {qs[0], tea_raw};
         end
         assign tea_late = qs[1];
      end
   endgenerate
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic          run,
   input  logic          en,
   input  logic [CW-1:0] limit,
   output logic          expire
);
   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim_q;
   logic          armed_q;

   initial begin
      if (CW < 2) $error("cycle_timer: CW must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         lim_q   <= '0;
         armed_q <= 1'b0;
      end else if (load) begin
         cnt_q   <= '0;
         lim_q   <= limit;
         armed_q <= en && (limit != '0);
      end else if (run && cnt_q != '1) begin
         cnt_q <= cnt_q + ONE;
      end
   end

   assign expire = run && armed_q && (cnt_q == lim_q - ONE);
endmodule

// File: rtl/term_decode.sv
module term_decode
   import bus_term_pkg::*;
(
   input  logic          active,
   input  logic          ta,
   input  logic          tea_late,
   input  logic          early_err,
   input  logic          expire,
   output term_outcome_t outcome
);
   always_comb begin
      outcome = OC_NONE;
      if (active) begin
         if (tea_late || early_err) outcome = OC_ERR;
         else if (ta)               outcome = OC_OK;
         else if (expire)           outcome = OC_TIMEOUT;
      end
   end
endmodule

// File: rtl/bus_term_mon.sv
module bus_term_mon
   import bus_term_pkg::*;
#(
   parameter int CW         = 8,
   parameter int TEA_STAGES = 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start_i,
   input  logic          ta_i,
   input  logic          tea_ext_i,
   input  logic          int_busy_i,
   input  logic          mon_en_i,
   input  logic [CW-1:0] mon_limit_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          err_o,
   output logic          to_flag_o,
   output logic          tea_oe_o,
   output logic          tea_out_o
);
   term_state_t   st_q;
   term_outcome_t oc;
   logic          early_q;
   logic          to_q;
   logic          tea_late;
   logic          expire;
   logic          accept;

   assign accept = (st_q == ST_IDLE) && start_i;

   tea_sampler #(.STAGES(TEA_STAGES)) u_samp (
      .clk(clk), .rst(rst), .tea_raw(tea_ext_i), .tea_late(tea_late)
   );

   cycle_timer #(.CW(CW)) u_tmr (
      .clk(clk), .rst(rst), .load(accept), .run(st_q == ST_RUN),
      .en(mon_en_i), .limit(mon_limit_i), .expire(expire)
   );

   term_decode u_dec (
      .active(st_q == ST_RUN), .ta(ta_i), .tea_late(tea_late),
      .early_err(early_q), .expire(expire), .outcome(oc)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= ST_IDLE;
         early_q <= 1'b0;
         to_q    <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start_i) begin
               st_q    <= ST_RUN;
               early_q <= tea_ext_i;
            end
            ST_RUN: begin
               unique case (oc)
                  OC_OK: begin
                     st_q <= ST_IDLE;
                     to_q <= 1'b0;
                  end
                  OC_ERR: begin
                     st_q <= int_busy_i ? ST_DRAIN : ST_IDLE;
                     to_q <= 1'b0;
                  end
                  OC_TIMEOUT: st_q <= ST_TOUT;
                  default: ;
               endcase
               if (oc != OC_NONE) early_q <= 1'b0;
            end
            ST_TOUT: begin
               st_q <= ST_NEG;
               to_q <= 1'b1;
            end
            ST_NEG:   st_q <= ST_IDLE;
            ST_DRAIN: if (!int_busy_i) st_q <= ST_IDLE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   assign done_o    = (st_q == ST_TOUT) || (oc == OC_OK) || (oc == OC_ERR);
   assign err_o     = (st_q == ST_TOUT) || (oc == OC_ERR);
   assign busy_o    = (st_q != ST_IDLE);
   assign to_flag_o = to_q;
   assign tea_oe_o  = (st_q == ST_TOUT) || (st_q == ST_NEG);
   assign tea_out_o = (st_q == ST_TOUT);
endmodule

// File: rtl/bus_term_chk.sv
module bus_term_chk (
   input logic clk,
   input logic rst,
   input logic start_i,
   input logic ta_i,
   input logic tea_ext_i,
   input logic busy_o,
   input logic done_o,
   input logic err_o,
   input logic to_flag_o,
   input logic tea_oe_o,
   input logic tea_out_o
);
   // R1: a clean end needs an acknowledge in that cycle
   p_ok_needs_ta_r1: assert property (@(posedge clk) disable iff (rst)
      (done_o && !err_o) |-> ta_i);

   // R3: error seen with an accepted start forces an error end next cycle
   p_start_tea_err_r3: assert property (@(posedge clk) disable iff (rst)
      (start_i && !busy_o && tea_ext_i) |=> (done_o && err_o));

   // R5: driving asserted is followed by an actively negated cycle
   p_fast_negate_r5: assert property (@(posedge clk) disable iff (rst)
      (tea_oe_o && tea_out_o) |=> (tea_oe_o && !tea_out_o));

   // R5: after the negate cycle the line is released
   p_release_r5: assert property (@(posedge clk) disable iff (rst)
      (tea_oe_o && !tea_out_o) |=> !tea_oe_o);

   // R7: timeout flag only rises after the block drove the error line
   p_flag_src_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(to_flag_o) |-> $past(tea_out_o));

   // R10: completion is a single pulse
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);
endmodule

bind bus_term_mon bus_term_chk u_chk (.*);

// File: tb/bus_term_mon_test.sv
module bus_term_mon_test;
   localparam int CW = 4;

   typedef struct {
      bit err;
      int lat;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst;
   logic          start_i = 1'b0, ta_i = 1'b0, tea_ext_i = 1'b0, int_busy_i = 1'b0;
   logic          mon_en_i = 1'b0;
   logic [CW-1:0] mon_limit_i = '0;
   logic          busy_o, done_o, err_o, to_flag_o, tea_oe_o, tea_out_o;

   int   total = 0, bad = 0, cyc = 0, t0 = 0;
   bit   finished = 0;
   exp_t sb[$];

   always #4 clk = ~clk;

   bus_term_mon #(.CW(CW), .TEA_STAGES(1)) uut (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      cyc++;
      if (!rst) begin
         if (start_i && !busy_o) t0 = cyc;
         if (done_o) begin
            if (sb.size() == 0) begin
               chk(0, "R8", "unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(err_o == e.err, "R1-4", "err_o", int'(err_o), int'(e.err));
               chk(cyc - t0 == e.lat, "R1-4", "latency", cyc - t0, e.lat);
            end
         end
      end
   end

   // driver: ta/tea positions relative to start cycle, -1 = never
   task automatic run(input int ta_at, input int tea_at, input bit e_err,
                      input int e_lat, input bit chk_drive);
      if (e_lat > 0) begin
         exp_t e;
         e.err = e_err;
         e.lat = e_lat;
         sb.push_back(e);
      end
      @(posedge clk) #1;
      start_i = 1'b1; ta_i = 1'b0; tea_ext_i = (tea_at == 0);
      for (int k = 1; k <= 14; k++) begin
         @(posedge clk) #1;
         start_i = 1'b0; ta_i = (k == ta_at); tea_ext_i = (k == tea_at);
         if (chk_drive) begin
            @(negedge clk);
            chk(tea_oe_o == (k == 4 || k == 5), "R5", "tea_oe_o",
                int'(tea_oe_o), int'(k == 4 || k == 5));
            chk(tea_out_o == (k == 4), "R5", "tea_out_o",
                int'(tea_out_o), int'(k == 4));
         end
      end
      @(posedge clk) #1;
      ta_i = 1'b0; tea_ext_i = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk(sb.size() == 0, "R1", "pending expected items", sb.size(), 0);
   endtask

   initial begin
      #(8 * 200000);
      chk(0, "R10", "watchdog expired", 1, 0);
      finish_run();
   end

   initial begin
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      chk(!busy_o && !done_o && !tea_oe_o && !to_flag_o, "R9", "reset outputs",
          int'({busy_o, done_o, tea_oe_o, to_flag_o}), 0);

      // R1: normal ends, with wait states and with none
      run(3, -1, 0, 3, 0);
      run(1, -1, 0, 1, 0);
      // R2: registered external error
      run(5, 2, 1, 3, 0);
      run(3, 2, 1, 3, 0);
      run(3, 3, 0, 3, 0);   // error only with final TA: missed
      // R3: error in start cycle wins over TA
      run(1, 0, 1, 1, 0);
      // R4/R5/R7: timeout with limit 3
      mon_en_i = 1'b1; mon_limit_i = 4'd3;
      run(-1, -1, 1, 4, 1);
      chk(to_flag_o == 1'b1, "R7", "to_flag after timeout", int'(to_flag_o), 1);
      run(3, -1, 0, 3, 0);  // R4: TA on last allowed cycle
      chk(to_flag_o == 1'b0, "R7", "to_flag after normal", int'(to_flag_o), 0);
      run(-1, -1, 1, 4, 0);
      run(-1, 2, 1, 3, 0);  // R7: external error clears flag
      chk(to_flag_o == 1'b0, "R7", "to_flag after ext err", int'(to_flag_o), 0);
      // R6: monitor disabled
      mon_limit_i = 4'd0;
      run(10, -1, 0, 10, 0);
      mon_en_i = 1'b0; mon_limit_i = 4'd3;
      run(8, -1, 0, 8, 0);

      // R8: drain after external error with internal side busy
      int_busy_i = 1'b1;
      run(-1, 1, 1, 2, 0);
      @(negedge clk);
      chk(busy_o == 1'b1, "R8", "busy while draining", int'(busy_o), 1);
      @(posedge clk) #1 start_i = 1'b1;
      @(posedge clk) #1 start_i = 1'b0; ta_i = 1'b1;
      @(posedge clk) #1 ta_i = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(busy_o == 1'b1, "R8", "busy after ignored start", int'(busy_o), 1);
      @(posedge clk) #1 int_busy_i = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(busy_o == 1'b0, "R8", "idle after drain", int'(busy_o), 0);
      chk(sb.size() == 0, "R8", "queue empty", sb.size(), 0);
      // R8: normal end ignores int_busy_i
      int_busy_i = 1'b1;
      run(2, -1, 0, 2, 0);
      @(negedge clk);
      chk(busy_o == 1'b0, "R8", "no drain on normal end", int'(busy_o), 0);
      int_busy_i = 1'b0;
      run(2, -1, 0, 2, 0);
      finish_run();
   end
endmodule